// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between the control pins at a processor core's boundary and the core's pending-interrupt logic. The pins are time-base enable, external interrupt, system management interrupt, machine check, checkstop, hard reset and soft reset. Pin activity arrives as events: a valid strobe, a pin index and the new level. The block keeps the last accepted level of every recognised pin. It acts only when an event carries a level different from the stored one.

Each accepted change becomes exactly one kind of action:
- setting or clearing a bit in a four-bit pending mask,
- latching a halt request,
- pulsing a system reset request, or
- starting or freezing the time base.

A single interrupt request to the core is high whenever any pending bit is set. Software retires pending bits through a per-bit acknowledge input.

Top module: `ipc_pin_conditioner`

## Requirements
- R1: An event whose level equals the stored level of its pin produces no action. In particular, a pending bit that was acknowledged is not set again by a repeat of the same level.
- R2: Pin index 7 is unrecognised. An event on it changes no output and no stored level.
- R3: The external-interrupt pin (index 1) drives pending bit 0, and the system-management pin (index 2) drives pending bit 1. A change to high sets the bit, and a change to low clears it.
- R4: The machine-check pin (index 3) sets pending bit 2 on a change from high to low. A change from low to high does nothing.
- R5: A change to high on the checkstop pin (index 4) sets `halt_req`. Only `rst_n` clears it; a change to low on the pin does not.
- R6: A change to high on the hard-reset pin (index 5) makes `sys_reset_req` high for exactly one cycle. A change to low does nothing.
- R7: The soft-reset pin (index 6) drives pending bit 3. A change to high sets it, and a change to low clears it.
- R8: The time-base pin (index 0) sets `tb_run` on a change to high and clears it on a change to low. It never alters the pending mask.
- R9: `irq_req` is high exactly when the pending mask is non-zero.
- R10: Each `ack_clr` bit clears its pending bit at the next clock. If an event sets the same bit in the same cycle, the set wins.
- R11: After reset, the pending mask, `halt_req`, `sys_reset_req`, `tb_run`, `irq_req` and every stored pin level are zero.
- R12: All outputs are registered. An event or acknowledge sampled at one rising edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Pin event strobe |
| ev_pin | input | 3 | Pin index: 0 time base, 1 external, 2 system management, 3 machine check, 4 checkstop, 5 hard reset, 6 soft reset |
| ev_level | input | 1 | New level of the indexed pin |
| ack_clr | input | 4 | Per-bit pending acknowledge |
| pending | output | 4 | Pending mask: bit 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_req | output | 1 | Combined interrupt request |
| halt_req | output | 1 | Sticky halt request |
| sys_reset_req | output | 1 | One-cycle system reset request |
| tb_run | output | 1 | Time base runs when high |

## Verification
The hardest case to reach from the ports is a repeated level arriving after an acknowledge. The machine-check bit must stay clear when a second high-to-low report arrives with the stored level already low, and the external bit must stay clear when a high level is reported again. The directed stimulus builds this up in order: it sets the bit, acknowledges it, then repeats the event. The random phase mixes repeated levels, unrecognised indices and acknowledges that coincide with sets, and every cycle is compared against a bench model.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int NUM_PINS = 7;
  localparam int PIN_W    = 3;
  localparam int NUM_PEND = 4;

  // pin indices (decoded by the event source, so the order is fixed)
  localparam int PIN_TBEN  = 0;
  localparam int PIN_EXT   = 1;
  localparam int PIN_SMI   = 2;
  localparam int PIN_MCHK  = 3;
  localparam int PIN_CSTOP = 4;
  localparam int PIN_HRST  = 5;
  localparam int PIN_SRST  = 6;

  // pending mask bit positions
  localparam int PB_EXT  = 0;
  localparam int PB_SMI  = 1;
  localparam int PB_MCHK = 2;
  localparam int PB_SRST = 3;
endpackage

// File: rtl/ipc_level_track.sv
module ipc_level_track #(
  parameter int NPINS = 7,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [IDXW-1:0]  ev_pin,
  input  logic             ev_level,
  output logic [NPINS-1:0] lvl_q,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] lvl_d;
  logic [NPINS-1:0] lvl_en;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic hit;
    always_comb begin
      hit       = ev_valid && (ev_pin == IDXW'(p));
      rise[p]   = hit && ev_level && !lvl_q[p];
      fall[p]   = hit && !ev_level && lvl_q[p];
      lvl_en[p] = rise[p] || fall[p];
      lvl_d[p]  = ev_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[p] <= 1'b0;
      end else if (lvl_en[p]) begin
        lvl_q[p] <= lvl_d[p];
      end
    end
  end
endmodule

// File: rtl/ipc_action_map.sv
module ipc_action_map
  import ipc_pkg::*;
#(
  parameter int NPINS = NUM_PINS,
  parameter int NPEND = NUM_PEND
) (
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  output logic [NPEND-1:0] pend_set,
  output logic [NPEND-1:0] pend_clr,
  output logic             halt_set,
  output logic             hrst_hit,
  output logic             tb_start,
  output logic             tb_stop
);
  always_comb begin
    pend_set = '0;
    pend_clr = '0;
    // level sensitive, active high
    pend_set[PB_EXT]  = rise[PIN_EXT];
    pend_clr[PB_EXT]  = fall[PIN_EXT];
    pend_set[PB_SMI]  = rise[PIN_SMI];
    pend_clr[PB_SMI]  = fall[PIN_SMI];
    pend_set[PB_SRST] = rise[PIN_SRST];
    pend_clr[PB_SRST] = fall[PIN_SRST];
    // negative edge only
    pend_set[PB_MCHK] = fall[PIN_MCHK];
    halt_set = rise[PIN_CSTOP];
    hrst_hit = rise[PIN_HRST];
    tb_start = rise[PIN_TBEN];
    tb_stop  = fall[PIN_TBEN];
  end
endmodule

// File: rtl/ipc_core_state.sv
module ipc_core_state #(
  parameter int NPEND = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPEND-1:0] pend_set,
  input  logic [NPEND-1:0] pend_clr,
  input  logic [NPEND-1:0] ack_clr,
  input  logic             halt_set,
  input  logic             hrst_hit,
  input  logic             tb_start,
  input  logic             tb_stop,
  output logic [NPEND-1:0] pend_q,
  output logic             irq_q,
  output logic             halt_q,
  output logic             srst_q,
  output logic             tb_q
);
  logic [NPEND-1:0] pend_d;
  logic             irq_d, halt_d, srst_d, tb_d;

  always_comb begin
    pend_d = ((pend_q & ~ack_clr) & ~pend_clr) | pend_set;
    irq_d  = |pend_d;
    halt_d = halt_q | halt_set;
    srst_d = hrst_hit;
    tb_d   = tb_q;
    if (tb_start) tb_d = 1'b1;
    else if (tb_stop) tb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      halt_q <= 1'b0;
      srst_q <= 1'b0;
      tb_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      halt_q <= halt_d;
      srst_q <= srst_d;
      tb_q   <= tb_d;
    end
  end
endmodule

// File: rtl/ipc_pin_conditioner.sv
module ipc_pin_conditioner
  import ipc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [PIN_W-1:0]    ev_pin,
  input  logic                ev_level,
  input  logic [NUM_PEND-1:0] ack_clr,
  output logic [NUM_PEND-1:0] pending,
  output logic                irq_req,
  output logic                halt_req,
  output logic                sys_reset_req,
  output logic                tb_run
);
  logic [NUM_PINS-1:0] lvl_q, rise, fall;
  logic [NUM_PEND-1:0] pend_set, pend_clr;
  logic                halt_set, hrst_hit, tb_start, tb_stop;
  logic                ext_lvl;

  assign ext_lvl = lvl_q[PIN_EXT];

  ipc_level_track #(.NPINS(NUM_PINS), .IDXW(PIN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin),
    .ev_level(ev_level), .lvl_q(lvl_q), .rise(rise), .fall(fall)
  );

  ipc_action_map #(.NPINS(NUM_PINS), .NPEND(NUM_PEND)) u_map (
    .rise(rise), .fall(fall), .pend_set(pend_set), .pend_clr(pend_clr),
    .halt_set(halt_set), .hrst_hit(hrst_hit), .tb_start(tb_start),
    .tb_stop(tb_stop)
  );

  ipc_core_state #(.NPEND(NUM_PEND)) u_state (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
    .ack_clr(ack_clr), .halt_set(halt_set), .hrst_hit(hrst_hit),
    .tb_start(tb_start), .tb_stop(tb_stop), .pend_q(pending),
    .irq_q(irq_req), .halt_q(halt_req), .srst_q(sys_reset_req),
    .tb_q(tb_run)
  );
endmodule

// File: rtl/ipc_pin_conditioner_sva.sv
module ipc_pin_conditioner_sva
  import ipc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                ev_valid,
  input logic [PIN_W-1:0]    ev_pin,
  input logic                ev_level,
  input logic [NUM_PEND-1:0] ack_clr,
  input logic [NUM_PEND-1:0] pending,
  input logic                irq_req,
  input logic                halt_req,
  input logic                sys_reset_req,
  input logic                tb_run,
  input logic                ext_lvl
);
  a_r1_same_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == PIN_W'(PIN_EXT) && ev_level == ext_lvl && ack_clr == '0)
    |=> $stable(pending));

  a_r2_unknown_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == 3'd7 && ack_clr == '0)
    |=> ($stable(pending) && $stable(halt_req) && $stable(tb_run) && !sys_reset_req));

  a_r4_mchk_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == PIN_W'(PIN_MCHK) && ev_level && ack_clr == '0)
    |=> $stable(pending));

  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halt_req);

  a_r6_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(ev_valid && ev_pin == PIN_W'(PIN_HRST) && ev_level));

  a_r6_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

  a_r8_tb_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == PIN_W'(PIN_TBEN) && ack_clr == '0) |=> $stable(pending));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |-> irq_req);

  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !irq_req);

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> ((pending & $past(ack_clr)) == '0));
endmodule

bind ipc_pin_conditioner ipc_pin_conditioner_sva u_sva (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin),
  .ev_level(ev_level), .ack_clr(ack_clr), .pending(pending),
  .irq_req(irq_req), .halt_req(halt_req), .sys_reset_req(sys_reset_req),
  .tb_run(tb_run), .ext_lvl(ext_lvl)
);

// File: tb/test_ipc_pin_conditioner.sv
module test_ipc_pin_conditioner;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_valid;
  logic [2:0] ev_pin;
  logic       ev_level;
  logic [3:0] ack_clr;
  logic [3:0] pending;
  logic       irq_req, halt_req, sys_reset_req, tb_run;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // bench model
  logic [6:0] m_lvl;
  logic [3:0] m_pend;
  logic       m_halt, m_rst, m_tb;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cycles <= cycles + 1;

  ipc_pin_conditioner i_ipc_pin_conditioner (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pin(ev_pin),
    .ev_level(ev_level), .ack_clr(ack_clr), .pending(pending),
    .irq_req(irq_req), .halt_req(halt_req), .sys_reset_req(sys_reset_req),
    .tb_run(tb_run)
  );

  // expected pending mask after one event and acknowledge
  function automatic logic [3:0] f_pend(input logic [3:0] cur, input logic [6:0] lv,
                                        input logic v, input logic [2:0] p,
                                        input logic l, input logic [3:0] a);
    logic [3:0] n;
    n = cur & ~a;
    if (v && p != 3'd7 && l != lv[p]) begin
      case (p)
        3'd1: n[0] = l;
        3'd2: n[1] = l;
        3'd3: if (!l) n[2] = 1'b1;
        3'd6: n[3] = l;
        default: ;
      endcase
    end
    return n;
  endfunction

  function automatic logic f_change(input logic [6:0] lv, input logic v,
                                    input logic [2:0] p, input logic l);
    return v && p != 3'd7 && l != lv[p];
  endfunction

  task automatic compare(input string tag);
    logic [7:0] act, exp;
    act = {pending, irq_req, halt_req, sys_reset_req, tb_run};
    exp = {m_pend, |m_pend, m_halt, m_rst, m_tb};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got pend=%b irq=%b halt=%b rst=%b tb=%b, expected pend=%b irq=%b halt=%b rst=%b tb=%b",
               tag, act[7:4], act[3], act[2], act[1], act[0],
               exp[7:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // called at a negative edge; returns at the next negative edge after checking
  task automatic step(input logic v, input logic [2:0] p, input logic l,
                      input logic [3:0] a, input string tag);
    logic ch;
    ev_valid = v; ev_pin = p; ev_level = l; ack_clr = a;
    ch = f_change(m_lvl, v, p, l);
    m_pend = f_pend(m_pend, m_lvl, v, p, l, a);
    m_rst = ch && p == 3'd5 && l;
    if (ch && p == 3'd4 && l) m_halt = 1'b1;
    if (ch && p == 3'd0) m_tb = l;
    if (ch) m_lvl[p] = l;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ack_clr = '0;
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    ev_valid = 1'b0; ev_pin = '0; ev_level = 1'b0; ack_clr = '0;
    rst_n = 1'b0;
    m_lvl = '0; m_pend = '0; m_halt = 1'b0; m_rst = 1'b0; m_tb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    ev_valid = 1'b0; ev_pin = '0; ev_level = 1'b0; ack_clr = '0; rst_n = 1'b0;
    @(negedge clk);
    do_reset("R11 reset state");

    step(1, 3'd1, 1, 4'b0000, "R3 ext high sets bit0");
    step(1, 3'd1, 1, 4'b0000, "R1 repeated ext high");
    step(1, 3'd1, 1, 4'b0001, "R10 ack bit0 with repeated level");
    step(0, 3'd0, 0, 4'b0000, "R1 no re-set after ack");
    step(1, 3'd1, 0, 4'b0000, "R3 ext low");
    step(1, 3'd2, 1, 4'b0000, "R3 smi high sets bit1");
    step(1, 3'd2, 0, 4'b0000, "R3 smi low clears bit1");
    step(1, 3'd3, 1, 4'b0000, "R4 mchk rise ignored");
    step(1, 3'd3, 0, 4'b0000, "R4 mchk fall sets bit2");
    step(1, 3'd3, 0, 4'b0100, "R1 mchk repeated low with ack");
    step(1, 3'd3, 0, 4'b0000, "R1 mchk stays clear");
    step(1, 3'd0, 1, 4'b0000, "R8 tb start");
    step(1, 3'd0, 0, 4'b0000, "R8 tb freeze");
    step(1, 3'd4, 1, 4'b0000, "R5 checkstop halts");
    step(1, 3'd4, 0, 4'b0000, "R5 halt held after pin low");
    step(1, 3'd5, 1, 4'b0000, "R6 hard reset pulse");
    step(0, 3'd0, 0, 4'b0000, "R6 pulse is one cycle");
    step(1, 3'd5, 0, 4'b0000, "R6 fall ignored");
    step(1, 3'd6, 1, 4'b0000, "R7 soft reset sets bit3");
    step(1, 3'd6, 0, 4'b0000, "R7 soft reset clears bit3");
    step(1, 3'd7, 1, 4'b0000, "R2 unknown pin high");
    step(1, 3'd7, 0, 4'b0000, "R2 unknown pin low");
    step(1, 3'd1, 1, 4'b0001, "R10 set wins over ack");
    step(1, 3'd2, 1, 4'b0000, "R9 two bits pending");
    step(0, 3'd0, 0, 4'b0011, "R9 irq drops when mask empty");
    step(1, 3'd0, 1, 4'b0000, "R12 registered tb");
    do_reset("R5 reset releases halt");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] p;
      logic [3:0] a;
      p = 3'($urandom_range(0, 7));
      a = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0000;
      step(1'($urandom_range(0, 4) != 0), p, 1'($urandom), a, "R9 random mix");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule